// File: doc/BRIEF.md
# GPIO Interrupt Sense Bank

This block watches a bank of up to 32 already-synchronized GPIO input lines and turns selected activity on them into interrupt requests. Every line has four configuration bits: an interrupt-mode bit that admits the line to detection, a trigger bit that picks edge or level sensing, a polarity bit that picks the active sense, and a both-edge bit that makes an edge line fire on any transition.

Detected events land in a per-line status vector. Edge events are latched until software clears them by writing ones to a clear strobe. Level events track the pin on every cycle. A per-line enable vector gates the status. Enable bits are set through one write strobe, where ones set bits, and cleared through another, where zeros clear bits. Any enabled status bit raises the single interrupt output. The bus decoder outside the block supplies one strobe per register and a shared write-data word.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the status vector, the enable vector and the interrupt output are 0, and every configuration bit is 0, so no line is in interrupt mode.
- R2: A line in interrupt mode (mode bit 1) with trigger bit 0 and polarity bit 0 shows status equal to its pin, one clock after the pin changes, following the pin in both directions.
- R3: A level line with polarity bit 1 shows status equal to the inverted pin, one clock after the pin changes.
- R4: An edge line (trigger bit 1) with polarity 0 and both-edge 0 sets its status one clock after a 0-to-1 pin transition and keeps it after the pin returns to 0. A 1-to-0 transition does not set it.
- R5: An edge line with polarity 1 and both-edge 0 sets its status on a 1-to-0 transition and not on a 0-to-1 transition.
- R6: An edge line with both-edge bit 1 sets its status on either transition, whatever its polarity bit holds.
- R7: A line whose mode bit is 0 never shows status, whatever its pin does.
- R8: A clear write clears the latched status of each edge line whose data bit is 1. Lines whose data bit is 0 keep their status.
- R9: A clear write to an active level line has no lasting effect: its status is 1 again on the next cycle.
- R10: When a clear write and a new qualifying edge hit the same line in the same cycle, the status stays 1.
- R11: An unmask write sets the enable bit of each line whose data bit is 1. Data bits of 0 leave the enable bit unchanged. Without a mask or unmask write, the enable vector holds.
- R12: A mask write clears the enable bit of each line whose data bit is 0. Data bits of 1 leave the enable bit unchanged.
- R13: The interrupt output is 1 exactly while some line has both its status bit and its enable bit at 1. It is valid in the same cycle as those vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | LINES | Synchronized pin levels |
| wr_data_i | input | LINES | Shared write data for all strobes |
| wr_mode_i | input | 1 | Load the interrupt-mode bits from wr_data_i |
| wr_pol_i | input | 1 | Load the polarity bits |
| wr_trig_i | input | 1 | Load the edge/level trigger bits |
| wr_both_i | input | 1 | Load the both-edge bits |
| wr_clr_i | input | 1 | Clear the status of lines whose data bit is 1 |
| wr_mask_i | input | 1 | Disable the lines whose data bit is 0 |
| wr_unmask_i | input | 1 | Enable the lines whose data bit is 1 |
| status_o | output | LINES | Per-line detected status |
| enable_o | output | LINES | Per-line interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after the collision of a clear write with a fresh edge on the same line. A design that applies the clear last would drop that interrupt. It clears a level line that is still active, which catches a design that latches level status and loses the live pin. It writes zeros to the clear strobe, ones to the mask strobe and zeros to the unmask strobe, which shows up any design that treats those strobes as plain loads. It also flips the polarity of a both-edge line, so a design that lets polarity win over the both-edge bit misses the transition. A final reset is followed by a cycle with all pins low, so configuration that survives reset shows up as a spurious active-low level status.

// File: rtl/gpio_irq_sense_pkg.sv
package gpio_irq_sense_pkg;

    // Edge qualification: prev/cur are the pin one cycle apart.
    function automatic logic edge_seen(input logic pol, input logic both,
                                       input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        if (both)
            return rise | fall;
        return pol ? fall : rise;
    endfunction

    // Level qualification: polarity 1 means active low.
    function automatic logic level_seen(input logic pol, input logic cur);
        return pol ? ~cur : cur;
    endfunction

endpackage

// File: rtl/sense_cfg_regs.sv
module sense_cfg_regs #(
    parameter int LINES      = 32,
    parameter bit BOTH_EDGES = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] wr_data_i,
    input  logic             wr_mode_i,
    input  logic             wr_pol_i,
    input  logic             wr_trig_i,
    input  logic             wr_both_i,
    output logic [LINES-1:0] mode_o,
    output logic [LINES-1:0] pol_o,
    output logic [LINES-1:0] trig_o,
    output logic [LINES-1:0] both_o
);
    typedef struct packed {
        logic [LINES-1:0] mode;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] trig;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mode_i) cfg_d.mode = wr_data_i;
        if (wr_pol_i)  cfg_d.pol  = wr_data_i;
        if (wr_trig_i) cfg_d.trig = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.mode;
    assign pol_o  = cfg_q.pol;
    assign trig_o = cfg_q.trig;

    // The both-edge bits exist only when the variant asks for them.
    generate
        if (BOTH_EDGES) begin : g_both
            logic [LINES-1:0] both_d, both_q;

            always_comb begin
                both_d = both_q;
                if (wr_both_i) both_d = wr_data_i;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) both_q <= '0;
                else         both_q <= both_d;
            end

            assign both_o = both_q;
        end else begin : g_no_both
            logic unused_both;
            assign unused_both = wr_both_i;
            assign both_o      = '0;
        end
    endgenerate
endmodule

// File: rtl/sense_detect.sv
module sense_detect #(
    parameter int LINES = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] pol_i,
    input  logic [LINES-1:0] trig_i,
    input  logic [LINES-1:0] both_i,
    output logic [LINES-1:0] hit_o
);
    import gpio_irq_sense_pkg::*;

    typedef struct packed {
        logic [LINES-1:0] prev;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.prev = pin_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
    end

    // One qualifier per line: edge against last cycle, or live level.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            assign hit_o[g] = trig_i[g]
                ? edge_seen(pol_i[g], both_i[g], hist_q.prev[g], pin_i[g])
                : level_seen(pol_i[g], pin_i[g]);
        end
    endgenerate
endmodule

// File: rtl/sense_mask.sv
module sense_mask #(
    parameter int LINES = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] wr_data_i,
    input  logic             wr_mask_i,
    input  logic             wr_unmask_i,
    output logic [LINES-1:0] enable_o
);
    typedef struct packed {
        logic [LINES-1:0] en;
    } mask_t;

    mask_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_unmask_i) mask_d.en = mask_d.en | wr_data_i;
        if (wr_mask_i)   mask_d.en = mask_d.en & wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q <= '0;
        else         mask_q <= mask_d;
    end

    assign enable_o = mask_q.en;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int LINES      = 32,
    parameter bit BOTH_EDGES = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] wr_data_i,
    input  logic             wr_mode_i,
    input  logic             wr_pol_i,
    input  logic             wr_trig_i,
    input  logic             wr_both_i,
    input  logic             wr_clr_i,
    input  logic             wr_mask_i,
    input  logic             wr_unmask_i,
    output logic [LINES-1:0] status_o,
    output logic [LINES-1:0] enable_o,
    output logic             irq_o
);
    logic [LINES-1:0] mode_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] trig_q;
    logic [LINES-1:0] both_q;
    logic [LINES-1:0] hit;

    sense_cfg_regs #(.LINES(LINES), .BOTH_EDGES(BOTH_EDGES)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_data_i (wr_data_i),
        .wr_mode_i (wr_mode_i),
        .wr_pol_i  (wr_pol_i),
        .wr_trig_i (wr_trig_i),
        .wr_both_i (wr_both_i),
        .mode_o    (mode_q),
        .pol_o     (pol_q),
        .trig_o    (trig_q),
        .both_o    (both_q)
    );

    sense_detect #(.LINES(LINES)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .pol_i  (pol_q),
        .trig_i (trig_q),
        .both_i (both_q),
        .hit_o  (hit)
    );

    sense_mask #(.LINES(LINES)) u_mask (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_data_i   (wr_data_i),
        .wr_mask_i   (wr_mask_i),
        .wr_unmask_i (wr_unmask_i),
        .enable_o    (enable_o)
    );

    typedef struct packed {
        logic [LINES-1:0] st;
    } stat_t;

    stat_t stat_d, stat_q;
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] edge_keep;

    always_comb begin
        clr_vec   = wr_clr_i ? wr_data_i : '0;
        // Edge lines: new hit wins over a same-cycle clear.
        edge_keep = hit | (stat_q.st & ~clr_vec);
        stat_d    = stat_q;
        stat_d.st = mode_q & ((trig_q & edge_keep) | (~trig_q & hit));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign status_o = stat_q.st;
    assign irq_o    = |(stat_q.st & enable_o);
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
    parameter int LINES = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [LINES-1:0] wr_data_i,
    input logic             wr_mask_i,
    input logic             wr_unmask_i,
    input logic [LINES-1:0] mode_q,
    input logic [LINES-1:0] status_o,
    input logic [LINES-1:0] enable_o,
    input logic             irq_o
);
    // R1: one clock into reset everything is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (status_o == '0 && enable_o == '0 && !irq_o));

    // R7: a line out of interrupt mode shows no status.
    assert_mode_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & ~$past(mode_q)) == '0));

    // R11: ones written to the unmask strobe appear in the enable vector.
    assert_unmask_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_unmask_i && !wr_mask_i) |=> ((enable_o & $past(wr_data_i)) == $past(wr_data_i)));

    // R11: with no mask-side write the enable vector holds.
    assert_enable_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_mask_i && !wr_unmask_i) |=> (enable_o == $past(enable_o)));

    // R12: zeros written to the mask strobe are cleared.
    assert_mask_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_mask_i |=> ((enable_o & ~$past(wr_data_i)) == '0));

    // R13: a request needs some status and some enable.
    assert_irq_source_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_o != '0 && enable_o != '0));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.LINES(LINES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_data_i   (wr_data_i),
    .wr_mask_i   (wr_mask_i),
    .wr_unmask_i (wr_unmask_i),
    .mode_q      (mode_q),
    .status_o    (status_o),
    .enable_o    (enable_o),
    .irq_o       (irq_o)
);

// File: tb/gpio_irq_sense_test.sv
module gpio_irq_sense_test;
    localparam int LINES = 8;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic [LINES-1:0] pin = '0;
    logic [LINES-1:0] wr_data = '0;
    logic wr_mode = 0, wr_pol = 0, wr_trig = 0, wr_both = 0;
    logic wr_clr = 0, wr_mask = 0, wr_unmask = 0;
    logic [LINES-1:0] status;
    logic [LINES-1:0] enable;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_irq_sense #(.LINES(LINES)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .pin_i       (pin),
        .wr_data_i   (wr_data),
        .wr_mode_i   (wr_mode),
        .wr_pol_i    (wr_pol),
        .wr_trig_i   (wr_trig),
        .wr_both_i   (wr_both),
        .wr_clr_i    (wr_clr),
        .wr_mask_i   (wr_mask),
        .wr_unmask_i (wr_unmask),
        .status_o    (status),
        .enable_o    (enable),
        .irq_o       (irq)
    );

    // Line plan: 0 level high, 1 level low, 2 rising, 3 falling,
    // 4 both edges, 5..7 out of interrupt mode.
    // Row = {pin, clear data, expected status}; enable is all ones.
    localparam logic [23:0] VECS [8] = '{
        {8'h3F, 8'h00, 8'h15},
        {8'h00, 8'h00, 8'h1E},
        {8'h00, 8'h1C, 8'h02},
        {8'h00, 8'h03, 8'h02},
        {8'h1C, 8'h1C, 8'h16},
        {8'h1C, 8'h04, 8'h12},
        {8'h00, 8'h00, 8'h1A},
        {8'h20, 8'h00, 8'h1A}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // sel: 0 mode, 1 polarity, 2 trigger, 3 both, 4 clear, 5 mask, 6 unmask
    task automatic wr(input int sel, input logic [LINES-1:0] d);
        @(negedge clk);
        wr_data = d;
        case (sel)
            0: wr_mode   = 1'b1;
            1: wr_pol    = 1'b1;
            2: wr_trig   = 1'b1;
            3: wr_both   = 1'b1;
            4: wr_clr    = 1'b1;
            5: wr_mask   = 1'b1;
            default: wr_unmask = 1'b1;
        endcase
        @(negedge clk);
        {wr_mode, wr_pol, wr_trig, wr_both, wr_clr, wr_mask, wr_unmask} = '0;
    endtask

    task automatic step(input logic [LINES-1:0] p, input logic [LINES-1:0] c);
        @(negedge clk);
        pin = p;
        if (c != '0) begin
            wr_data = c;
            wr_clr  = 1'b1;
        end
        @(negedge clk);
        wr_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", status, 0);
        check("R1 reset enable", enable, 0);
        check("R1 reset irq", irq, 0);
        rst_ni = 1'b1;

        wr(0, 8'h1F);
        wr(2, 8'h1C);
        wr(1, 8'h0A);
        wr(3, 8'h10);
        wr(6, 8'hFF);
        check("R3 idle low pin on active-low level line", status, 8'h02);
        check("R11 unmask all", enable, 8'hFF);

        for (int k = 0; k < 8; k++) begin
            step(VECS[k][23:16], VECS[k][15:8]);
            check($sformatf("table row %0d status (R2 R3 R4 R5 R6 R7 R8 R9 R10)", k),
                  status, VECS[k][7:0]);
            check($sformatf("table row %0d irq (R13)", k), irq, VECS[k][7:0] != 0);
        end

        wr(4, 8'h1C);
        check("R8 clear edge lines", status, 8'h02);
        wr(5, 8'hFD);
        check("R12 mask zero clears", enable, 8'hFD);
        check("R13 irq low with only masked status", irq, 0);
        wr(5, 8'hFF);
        check("R12 mask ones no effect", enable, 8'hFD);
        wr(6, 8'h00);
        check("R11 unmask zeros no effect", enable, 8'hFD);
        wr(6, 8'h02);
        check("R11 unmask sets bit", enable, 8'hFF);
        check("R13 irq high when enabled", irq, 1);

        wr(1, 8'h1A);
        check("R6 polarity change leaves status", status, 8'h02);
        step(8'h30, 8'h00);
        check("R6 both-edge line with polarity 1 sees rise", status, 8'h12);

        step(8'h00, 8'h00);
        @(negedge clk);
        rst_ni = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset status", status, 0);
        check("R1 mid-run reset enable", enable, 0);
        check("R1 mid-run reset irq", irq, 0);
        rst_ni = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 config cleared by reset", status, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule